// File: doc/BRIEF.md
# Chained Descriptor Transfer Engine

The engine moves one byte per trigger pulse, using descriptors that software loads into an internal register file. Each descriptor holds a source address, a destination address, a transfer count, the source and count values to reload, and a control byte. The control byte selects the mode, the chaining rule, interrupt muting and whether the descriptor patches another descriptor. A trigger runs one chain step. The engine reads the source over a request/ready memory port, writes the destination, then updates the descriptor. The step then moves on to the next descriptor, or it ends.

The main use is an endless capture into a buffer that is larger than the low destination field can address. Descriptor 0 runs in normal mode and fills one page. When its count runs out it chains to descriptor 1. Descriptor 1 runs in repeat mode and reads the next page number from a small table in memory. It writes that byte into the upper byte of descriptor 0's destination, without any memory write. When descriptor 1's own count runs out, its table pointer and count reload, so the page sequence loops forever.

The controller is a four-state machine:
- ST_IDLE: no step in progress.
- ST_FETCH: the read cycle.
- ST_STORE: the write cycle.
- ST_UPDATE: the descriptor write-back.

The transitions are:
- ST_IDLE→ST_FETCH when a trigger or a pending trigger is present.
- ST_FETCH→ST_STORE when the read completes on a memory descriptor.
- ST_FETCH→ST_UPDATE when the read completes on a patching descriptor.
- ST_STORE→ST_UPDATE when the write completes.
- ST_UPDATE→ST_FETCH to run the chained descriptor, or to restart at descriptor 0 for a held trigger.
- ST_UPDATE→ST_IDLE otherwise.

Top module: `xfer_chain_engine`

## Requirements
- R1: After reset, busy, irq_req and mem_req are low, and every descriptor field is zero.
- R2: A configuration write stores cfg_data into the field of descriptor cfg_idx named by cfg_fld. The codes are 0 for source (also sets the reload source), 1 for destination, 2 for count (also sets the reload count) and 3 for control. A configuration write while busy is high is ignored.
- R3: Control bits are: bit0 repeat mode, bit1 chain enable, bit2 chain only on zero, bit3 interrupt mute, bit4 patch. In normal mode the source stays fixed. The low AW-DW bits of the destination increment and wrap, and the upper DW bits of the destination are kept.
- R4: The count decrements once per transfer and reaches zero on the transfer that starts with count 1. A count loaded as 0 therefore gives 2^CW transfers before it reaches zero.
- R5: Each transfer is one read of the source followed by one write of the data to the destination. mem_req, mem_addr and mem_we stay stable until mem_ready is seen.
- R6: With chain enable and chain-on-zero both set, the next descriptor runs only on the transfer where the count reaches zero.
- R7: With chain enable set and chain-on-zero clear, the next descriptor runs after every transfer. With chain enable clear, or on the last descriptor, the step ends.
- R8: A patching descriptor performs no memory write. It writes the byte it read into the upper DW bits of descriptor 0's destination.
- R9: In repeat mode the source increments and the destination is fixed. On reaching zero, the source and the count reload to their loaded values.
- R10: irq_req pulses for one cycle after a non-repeat descriptor's count reaches zero with interrupt mute clear. It never pulses for a repeat descriptor or while mute is set.
- R11: busy rises in the cycle after the trigger and stays high until the final update. A trigger that arrives while busy is held in one pending flag and restarts the chain at descriptor 0. Further triggers are lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_trig | input | 1 | Trigger pulse for one chain step |
| cfg_we | input | 1 | Descriptor field write strobe |
| cfg_idx | input | IW | Descriptor index |
| cfg_fld | input | 2 | Field code |
| cfg_data | input | AW | Field value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ready |
| mem_ready | input | 1 | Completes the current request |
| busy | output | 1 | Chain step in progress |
| irq_req | output | 1 | One-cycle interrupt request |

## Verification
The bench builds the engine with AW=12, CW=4, DW=8 and NDESC=2. With these values a count loaded as zero expires after 16 transfers, and the low four destination bits wrap on the same transfer. A complete loop of the two-entry page table, including its reload back to the first entry, therefore takes about fifty triggers. The small destination field also lets a wrap inside a page be seen with three writes, and the patched page change shows up as a jump in the written addresses.

// File: rtl/xce_pkg.sv
package xce_pkg;

    typedef enum logic [1:0] {
        FLD_SRC = 2'd0,
        FLD_DST = 2'd1,
        FLD_CNT = 2'd2,
        FLD_CTL = 2'd3
    } fld_e;

    typedef struct packed {
        logic patch_up;
        logic irq_mute;
        logic chain_on_zero;
        logic chain_on;
        logic rpt;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_STORE,
        ST_UPDATE
    } st_e;

endpackage

// File: rtl/xce_step.sv
module xce_step
    import xce_pkg::*;
#(
    parameter int AW = 24,
    parameter int CW = 16,
    parameter int DW = 8
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic [AW-1:0] src0,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cnt0,
    input  ctl_t          ctl,
    output logic [AW-1:0] nsrc,
    output logic [AW-1:0] ndst,
    output logic [CW-1:0] ncnt,
    output logic          hit_zero
);
    localparam int LW = AW - DW;

    always_comb begin
        hit_zero = (cnt == CW'(1));
        ncnt     = cnt - CW'(1);
        nsrc     = src;
        ndst     = dst;
        if (ctl.rpt) begin
            nsrc = src + AW'(1);
            if (hit_zero) begin
                nsrc = src0;
                ncnt = cnt0;
            end
        end else begin
            ndst = {dst[AW-1:LW], dst[LW-1:0] + LW'(1)};
        end
    end

endmodule

// File: rtl/xce_desc_file.sv
module xce_desc_file
    import xce_pkg::*;
#(
    parameter int NDESC = 2,
    parameter int AW    = 24,
    parameter int CW    = 16,
    parameter int DW    = 8,
    localparam int IW   = (NDESC > 1) ? $clog2(NDESC) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_idx,
    input  logic [1:0]    cfg_fld,
    input  logic [AW-1:0] cfg_data,
    input  logic [IW-1:0] sel_idx,
    input  logic          upd_en,
    input  logic [AW-1:0] nsrc,
    input  logic [AW-1:0] ndst,
    input  logic [CW-1:0] ncnt,
    input  logic          patch_en,
    input  logic [DW-1:0] patch_byte,
    output logic [AW-1:0] cur_src,
    output logic [AW-1:0] cur_dst,
    output logic [AW-1:0] cur_src0,
    output logic [CW-1:0] cur_cnt,
    output logic [CW-1:0] cur_cnt0,
    output ctl_t          cur_ctl
);
    logic [AW-1:0] src_q  [NDESC];
    logic [AW-1:0] dst_q  [NDESC];
    logic [AW-1:0] src0_q [NDESC];
    logic [CW-1:0] cnt_q  [NDESC];
    logic [CW-1:0] cnt0_q [NDESC];
    ctl_t          ctl_q  [NDESC];

    fld_e fld;
    assign fld = fld_e'(cfg_fld);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NDESC; i++) begin
                src_q[i]  <= '0;
                dst_q[i]  <= '0;
                src0_q[i] <= '0;
                cnt_q[i]  <= '0;
                cnt0_q[i] <= '0;
                ctl_q[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < NDESC; i++) begin
                if (cfg_we && cfg_idx == IW'(i)) begin
                    unique case (fld)
                        FLD_SRC: begin
                            src_q[i]  <= cfg_data;
                            src0_q[i] <= cfg_data;
                        end
                        FLD_DST: dst_q[i] <= cfg_data;
                        FLD_CNT: begin
                            cnt_q[i]  <= cfg_data[CW-1:0];
                            cnt0_q[i] <= cfg_data[CW-1:0];
                        end
                        FLD_CTL: ctl_q[i] <= ctl_t'(cfg_data[CTL_W-1:0]);
                    endcase
                end else if (upd_en && sel_idx == IW'(i)) begin
                    src_q[i] <= nsrc;
                    dst_q[i] <= ndst;
                    cnt_q[i] <= ncnt;
                end
            end
            if (patch_en) begin
                dst_q[0][AW-1 -: DW] <= patch_byte;
            end
        end
    end

    assign cur_src  = src_q[sel_idx];
    assign cur_dst  = dst_q[sel_idx];
    assign cur_src0 = src0_q[sel_idx];
    assign cur_cnt  = cnt_q[sel_idx];
    assign cur_cnt0 = cnt0_q[sel_idx];
    assign cur_ctl  = ctl_q[sel_idx];

    // R9
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !cfg_we && cur_ctl.rpt && cur_cnt == CW'(1))
            |=> (cnt_q[$past(sel_idx)] == cnt0_q[$past(sel_idx)]
                 && src_q[$past(sel_idx)] == src0_q[$past(sel_idx)]));

    // R8
    patch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        patch_en |=> (dst_q[0][AW-1 -: DW] == $past(patch_byte)));

endmodule

// File: rtl/xce_ctrl.sv
module xce_ctrl
    import xce_pkg::*;
#(
    parameter int NDESC = 2,
    localparam int IW   = (NDESC > 1) ? $clog2(NDESC) : 1,
    localparam int LAST = NDESC - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic          mem_ready,
    input  ctl_t          cur_ctl,
    input  logic          hit_zero,
    output logic          mem_req,
    output logic          mem_we,
    output logic          fetch_ph,
    output logic          cap_en,
    output logic          upd_en,
    output logic          patch_en,
    output logic [IW-1:0] cur_idx,
    output logic          busy,
    output logic          irq
);
    st_e           st_q, st_d;
    logic          pend_q;
    logic [IW-1:0] idx_q;
    logic          irq_q;
    logic          chain_go;

    assign chain_go = cur_ctl.chain_on
                   && (!cur_ctl.chain_on_zero || hit_zero)
                   && (idx_q != IW'(LAST));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (trig || pend_q) st_d = ST_FETCH;
            ST_FETCH:  if (mem_ready) st_d = cur_ctl.patch_up ? ST_UPDATE : ST_STORE;
            ST_STORE:  if (mem_ready) st_d = ST_UPDATE;
            ST_UPDATE: st_d = (chain_go || pend_q || trig) ? ST_FETCH : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            idx_q  <= '0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= (st_q == ST_UPDATE) && !cur_ctl.rpt && hit_zero && !cur_ctl.irq_mute;
            if (st_q == ST_IDLE) begin
                pend_q <= 1'b0;
                idx_q  <= '0;
            end else if (st_q == ST_UPDATE && !chain_go) begin
                pend_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                if (trig) pend_q <= 1'b1;
                if (st_q == ST_UPDATE) idx_q <= idx_q + IW'(1);
            end
        end
    end

    always_comb begin
        mem_req  = (st_q == ST_FETCH) || (st_q == ST_STORE);
        mem_we   = (st_q == ST_STORE);
        fetch_ph = (st_q == ST_FETCH);
        cap_en   = (st_q == ST_FETCH) && mem_ready;
        upd_en   = (st_q == ST_UPDATE);
        patch_en = (st_q == ST_UPDATE) && cur_ctl.patch_up;
        busy     = (st_q != ST_IDLE);
        cur_idx  = idx_q;
        irq      = irq_q;
    end

    // R10
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(upd_en && !cur_ctl.rpt && !cur_ctl.irq_mute && hit_zero));

    // R6
    chain_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && idx_q == '0 && cur_ctl.chain_on && cur_ctl.chain_on_zero && !hit_zero)
            |=> (idx_q == '0));

    // R11
    idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !trig && !pend_q) |=> !busy);

endmodule

// File: rtl/xfer_chain_engine.sv
module xfer_chain_engine
    import xce_pkg::*;
#(
    parameter int NDESC = 2,
    parameter int AW    = 24,
    parameter int CW    = 16,
    parameter int DW    = 8,
    localparam int IW   = (NDESC > 1) ? $clog2(NDESC) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer_trig,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_idx,
    input  logic [1:0]    cfg_fld,
    input  logic [AW-1:0] cfg_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          busy,
    output logic          irq_req
);
    logic [AW-1:0] cur_src, cur_dst, cur_src0, nsrc, ndst;
    logic [CW-1:0] cur_cnt, cur_cnt0, ncnt;
    ctl_t          cur_ctl;
    logic          hit_zero, fetch_ph, cap_en, upd_en, patch_en;
    logic [IW-1:0] cur_idx;
    logic [DW-1:0] rd_q;

    xce_ctrl #(.NDESC(NDESC)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (xfer_trig),
        .mem_ready(mem_ready),
        .cur_ctl  (cur_ctl),
        .hit_zero (hit_zero),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .fetch_ph (fetch_ph),
        .cap_en   (cap_en),
        .upd_en   (upd_en),
        .patch_en (patch_en),
        .cur_idx  (cur_idx),
        .busy     (busy),
        .irq      (irq_req)
    );

    xce_desc_file #(.NDESC(NDESC), .AW(AW), .CW(CW), .DW(DW)) u_desc (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we && !busy),
        .cfg_idx   (cfg_idx),
        .cfg_fld   (cfg_fld),
        .cfg_data  (cfg_data),
        .sel_idx   (cur_idx),
        .upd_en    (upd_en),
        .nsrc      (nsrc),
        .ndst      (ndst),
        .ncnt      (ncnt),
        .patch_en  (patch_en),
        .patch_byte(rd_q),
        .cur_src   (cur_src),
        .cur_dst   (cur_dst),
        .cur_src0  (cur_src0),
        .cur_cnt   (cur_cnt),
        .cur_cnt0  (cur_cnt0),
        .cur_ctl   (cur_ctl)
    );

    xce_step #(.AW(AW), .CW(CW), .DW(DW)) u_step (
        .src     (cur_src),
        .dst     (cur_dst),
        .src0    (cur_src0),
        .cnt     (cur_cnt),
        .cnt0    (cur_cnt0),
        .ctl     (cur_ctl),
        .nsrc    (nsrc),
        .ndst    (ndst),
        .ncnt    (ncnt),
        .hit_zero(hit_zero)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_q <= '0;
        else if (cap_en) rd_q <= mem_rdata;
    end

    assign mem_addr  = fetch_ph ? cur_src : cur_dst;
    assign mem_wdata = rd_q;

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R8
    no_patch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_ph && mem_ready && cur_ctl.patch_up) |=> !mem_req);

endmodule

// File: tb/xfer_chain_engine_test.sv
`timescale 1ns/1ps
module xfer_chain_engine_test;
    localparam int AW = 12;
    localparam int CW = 4;
    localparam int DW = 8;
    localparam int NDESC = 2;
    localparam int TAB = 'h300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_trig = 1'b0;
    logic cfg_we = 1'b0;
    logic [0:0] cfg_idx = '0;
    logic [1:0] cfg_fld = '0;
    logic [AW-1:0] cfg_data = '0;
    logic mem_req, mem_we, mem_ready, busy, irq_req;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    logic poke_en = 1'b0;
    logic [AW-1:0] poke_addr = '0;
    logic [DW-1:0] poke_data = '0;
    logic [DW-1:0] mem [1 << AW];

    int wr_cnt, tab_cnt, irq_cnt, viol_cnt, last_tab;
    logic prev_hold;
    logic [AW-1:0] prev_addr;
    int checks = 0;
    int failures = 0;
    bit timed_out = 0;

    always #2 clk = ~clk;

    xfer_chain_engine #(.NDESC(NDESC), .AW(AW), .CW(CW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .xfer_trig(xfer_trig),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_fld(cfg_fld), .cfg_data(cfg_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .busy(busy), .irq_req(irq_req)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ready <= 1'b0;
            mem_rdata <= '0;
            for (int i = 0; i < (1 << AW); i++) mem[i] <= '0;
        end else begin
            mem_ready <= mem_req & ~mem_ready;
            if (mem_req && !mem_ready) mem_rdata <= mem[mem_addr];
            if (mem_req && mem_ready && mem_we) mem[mem_addr] <= mem_wdata;
            if (poke_en) mem[poke_addr] <= poke_data;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt <= 0; tab_cnt <= 0; irq_cnt <= 0; viol_cnt <= 0; last_tab <= 0;
            prev_hold <= 1'b0; prev_addr <= '0;
        end else begin
            if (mem_req && mem_ready && mem_we) wr_cnt <= wr_cnt + 1;
            if (mem_req && mem_ready && !mem_we && int'(mem_addr) >= TAB) begin
                tab_cnt <= tab_cnt + 1;
                last_tab <= int'(mem_addr);
            end
            if (irq_req) irq_cnt <= irq_cnt + 1;
            if (prev_hold && (!mem_req || mem_addr != prev_addr)) viol_cnt <= viol_cnt + 1;
            prev_hold <= mem_req & ~mem_ready;
            prev_addr <= mem_addr;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg(int idx, int fld, int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 1'(idx); cfg_fld = 2'(fld); cfg_data = AW'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic poke(int addr, int data);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = AW'(addr); poke_data = DW'(data);
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic fire(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); xfer_trig = 1'b1;
            @(negedge clk); xfer_trig = 1'b0;
            while (busy) @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 irq", int'(irq_req), 0);
        chk("R1 req", int'(mem_req), 0);
    endtask

    task automatic t_normal;
        int w0, i0, t0;
        poke('h100, 'h11);
        cfg(0, 0, 'h100); cfg(0, 1, 'h2FE); cfg(0, 2, 3); cfg(0, 3, 'h00);
        w0 = wr_cnt; i0 = irq_cnt; t0 = tab_cnt;
        fire(2);
        chk("R10 no irq before zero", irq_cnt - i0, 0);
        fire(1);
        chk("R10 irq at zero", irq_cnt - i0, 1);
        chk("R3 low wrap", int'(mem['h2F0]), 'h11);
        chk("R3 upper kept", int'(mem['h300]), 0);
        chk("R3 write 2FF", int'(mem['h2FF]), 'h11);
        chk("R5 one write per transfer", wr_cnt - w0, 3);
        chk("R7 no chain when disabled", tab_cnt - t0, 0);
        cfg(0, 1, 'h500); cfg(0, 2, 1); cfg(0, 3, 'h08);
        i0 = irq_cnt;
        fire(1);
        chk("R10 muted", irq_cnt - i0, 0);
        chk("R2 dst field", int'(mem['h500]), 'h11);
    endtask

    task automatic t_pending;
        int w0;
        cfg(0, 1, 'h600); cfg(0, 2, 0); cfg(0, 3, 'h00);
        w0 = wr_cnt;
        @(negedge clk); xfer_trig = 1'b1;
        @(negedge clk);
        chk("R11 busy after trigger", int'(busy), 1);
        repeat (2) @(negedge clk);
        xfer_trig = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        chk("R11 single pending", wr_cnt - w0, 2);
        chk("R11 second write", int'(mem['h601]), 'h11);
        chk("R11 no third", int'(mem['h602]), 0);
    endtask

    task automatic t_cfg_busy;
        cfg(0, 1, 'h700);
        @(negedge clk); xfer_trig = 1'b1;
        @(negedge clk); xfer_trig = 1'b0;
        cfg_we = 1'b1; cfg_idx = 1'b0; cfg_fld = 2'd1; cfg_data = AW'('h7A0);
        @(negedge clk); cfg_we = 1'b0;
        while (busy) @(negedge clk);
        fire(1);
        chk("R2 write while busy ignored", int'(mem['h701]), 'h11);
        chk("R2 no write at ignored dst", int'(mem['h7A0]), 0);
    endtask

    task automatic t_chain_zero;
        int i0, t0, w0;
        poke(TAB, 'h21); poke(TAB + 1, 'h20);
        cfg(0, 0, 'h100); cfg(0, 1, 'h200); cfg(0, 2, 0); cfg(0, 3, 'h06);
        cfg(1, 0, TAB); cfg(1, 2, 2); cfg(1, 3, 'h11);
        i0 = irq_cnt; t0 = tab_cnt;
        fire(15);
        chk("R6 no chain before zero", tab_cnt - t0, 0);
        chk("R4 no expiry after 15", irq_cnt - i0, 0);
        w0 = wr_cnt;
        fire(1);
        chk("R4 expiry at 16", irq_cnt - i0, 1);
        chk("R6 chain at zero", tab_cnt - t0, 1);
        chk("R8 patch no mem write", wr_cnt - w0, 1);
        poke('h100, 'h22);
        fire(1);
        chk("R8 page patched", int'(mem['h210]), 'h22);
        fire(15);
        chk("R9 second table entry", last_tab, TAB + 1);
        poke('h100, 'h33);
        fire(1);
        chk("R8 back to first page", int'(mem['h200]), 'h33);
        fire(15);
        chk("R9 table reloaded", last_tab, TAB);
        poke('h100, 'h44);
        fire(1);
        chk("R9 loop repeats", int'(mem['h210]), 'h44);
        chk("R10 repeat never irq", irq_cnt - i0, 3);
    endtask

    task automatic t_chain_every;
        int t0;
        poke('h100, 'h55);
        cfg(0, 1, 'h800); cfg(0, 2, 0); cfg(0, 3, 'h02);
        cfg(1, 0, TAB); cfg(1, 2, 2); cfg(1, 3, 'h11);
        t0 = tab_cnt;
        fire(2);
        chk("R7 chain each transfer", tab_cnt - t0, 2);
        chk("R7 first write", int'(mem['h800]), 'h55);
        chk("R7 patched after one", int'(mem['h211]), 'h55);
        chk("R5 handshake held", viol_cnt, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fork
            begin
                t_reset();
                t_normal();
                t_pending();
                t_cfg_busy();
                t_chain_zero();
                t_chain_every();
            end
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        if (timed_out) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule